// File: doc/BRIEF.md
# Scheduling Tag State Tracker

This block follows the scheduling tag type and the tag value that one processing core holds inside a work-ordering scheduler. The core sends single-cycle requests: a tag switch (with a target type and tag), a work grant (carrying the granted type and tag), a deschedule, and a null-switch load. The block applies each legal request to its held type and tag and acknowledges it. It flags each illegal request, rejects it, and leaves the held state as it was.

The tag type tells the core how it may process its current work. An ordered tag keeps order with other work. An atomic tag keeps that order and also guarantees that only one core owns the tag at a time. A null tag means the core holds no ordering. The empty type (null-null) means the core holds no work and has no reserved slot. The block starts in the empty type. The empty type may be left only by a work grant or by a null-switch load. An output tells downstream logic when the core holds an atomic tag.

The block models one core. It does not cover the queue memory, the ordering lists across cores, or arbitration between cores.

Top module: `sched_tag_tracker`

## Requirements
- R1: The tag type is encoded in 2 bits: 0 ordered, 1 atomic, 2 null, 3 empty (null-null). After reset the type is 3, the tag is 0, and both `done_o` and `err_o` are low.
- R2: A tag switch is legal when it goes from ordered, atomic or null to ordered, atomic or null, except from null to null. A legal switch loads the target type and the 32-bit tag at the next clock edge. `done_o` is high for the following cycle only.
- R3: A deschedule is legal from any type. It sets the type to 3 (empty), clears the tag to 0, and pulses `done_o`.
- R4: The type leaves empty (3) only through an accepted work grant or an accepted null-switch load.
- R5: A work grant whose type is 0, 1 or 2 is legal from any type and loads the granted type and tag. A grant whose type is 3 is illegal.
- R6: An illegal request pulses `err_o` for one cycle with `done_o` low, and leaves the type and the tag unchanged.
- R7: A tag switch is illegal when its target is 3, when the current type is 3, or when it goes from null (2) to null.
- R8: `atomic_o` is high exactly when the current type is 1 (atomic).
- R9: At most one request is accepted per clock edge. The priority is deschedule, then work grant, then null-switch load, then tag switch. Lower-priority requests presented in the same cycle are dropped and have no effect.
- R10: A null-switch load sets the type to 2 (null) and keeps the tag. It is legal from types 0, 1 and 3, and illegal from type 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desched_i | input | 1 | Deschedule request |
| gnt_i | input | 1 | Work grant request |
| gnt_type_i | input | 2 | Type carried by the grant |
| gnt_tag_i | input | 32 | Tag carried by the grant |
| nsw_i | input | 1 | Null-switch load request |
| sw_i | input | 1 | Tag switch request |
| sw_type_i | input | 2 | Target type of the switch |
| sw_tag_i | input | 32 | Target tag of the switch |
| cur_type_o | output | 2 | Current tag type |
| cur_tag_o | output | 32 | Current tag value |
| atomic_o | output | 1 | Core holds an atomic tag |
| done_o | output | 1 | Previous-cycle request succeeded |
| err_o | output | 1 | Previous-cycle request was illegal |

## Verification
The bench tests each way into and out of the empty type:
- A tag switch issued while empty. A design that allowed it would let a core gain ordering without any work.
- A switch whose target is empty. A design that allowed it would drop the reserved slot silently.
- A null-to-null switch and a null-switch load from null. A design that missed these checks would report `done_o` where `err_o` is required.
- A grant of the empty type.

Each rejected request is followed by a check that the type and tag did not change. This catches a design that flags the error but still updates its registers. Several requests are also presented together in different combinations. A design with the wrong priority would show a type or tag that belongs to the losing request.

// File: rtl/sched_tag_pkg.sv
package sched_tag_pkg;
  localparam int unsigned TYPE_W = 2;

  typedef enum logic [TYPE_W-1:0] {
    TT_ORDERED = 2'd0,
    TT_ATOMIC  = 2'd1,
    TT_NULL    = 2'd2,
    TT_EMPTY   = 2'd3
  } tag_type_e;

  // bit index in the request vector = priority rank, 0 highest
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_DESCHED = 3'd1,
    OP_GRANT   = 3'd2,
    OP_NSW     = 3'd3,
    OP_SWITCH  = 3'd4
  } tag_op_e;

  localparam int unsigned NUM_OPS = 4;

  typedef enum logic [1:0] {
    TA_KEEP  = 2'd0,
    TA_LOAD  = 2'd1,
    TA_CLEAR = 2'd2
  } tag_act_e;
endpackage

// File: rtl/sched_tag_arb.sv
module sched_tag_arb #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] win_o
);
  logic [N:0] taken;

  always_comb begin
    taken[0] = 1'b0;
    for (int i = 0; i < N; i++) begin
      win_o[i]   = req_i[i] & ~taken[i];
      taken[i+1] = taken[i] | req_i[i];
    end
  end

  AST_ONE_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_o)) else $error("more than one request accepted"); // R9

  AST_TOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |-> win_o[0]) else $error("highest request not accepted"); // R9

  AST_ANY_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> ($countones(win_o) == 1)) else $error("request lost"); // R9
endmodule

// File: rtl/sched_tag_rules.sv
module sched_tag_rules
  import sched_tag_pkg::*;
(
  input  tag_op_e   op_i,
  input  tag_type_e cur_type_i,
  input  tag_type_e req_type_i,
  output tag_type_e nxt_type_o,
  output tag_act_e  tag_act_o,
  output logic      apply_o,
  output logic      done_d_o,
  output logic      err_d_o
);
  logic      legal;
  tag_type_e nxt_raw;
  tag_act_e  act_raw;

  always_comb begin
    legal   = 1'b0;
    nxt_raw = cur_type_i;
    act_raw = TA_KEEP;
    unique case (op_i)
      OP_DESCHED: begin
        legal   = 1'b1;
        nxt_raw = TT_EMPTY;
        act_raw = TA_CLEAR;
      end
      OP_GRANT: begin
        legal   = (req_type_i != TT_EMPTY);
        nxt_raw = req_type_i;
        act_raw = TA_LOAD;
      end
      OP_NSW: begin
        legal   = (cur_type_i != TT_NULL);
        nxt_raw = TT_NULL;
        act_raw = TA_KEEP;
      end
      OP_SWITCH: begin
        legal   = (req_type_i != TT_EMPTY) && (cur_type_i != TT_EMPTY)
                  && !((cur_type_i == TT_NULL) && (req_type_i == TT_NULL));
        nxt_raw = req_type_i;
        act_raw = TA_LOAD;
      end
      default: ;
    endcase
  end

  assign apply_o    = (op_i != OP_NONE) && legal;
  assign nxt_type_o = apply_o ? nxt_raw : cur_type_i;
  assign tag_act_o  = apply_o ? act_raw : TA_KEEP;
  assign done_d_o   = apply_o;
  assign err_d_o    = (op_i != OP_NONE) && !legal;
endmodule

// File: rtl/sched_tag_state.sv
module sched_tag_state
  import sched_tag_pkg::*;
#(
  parameter int unsigned TAG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tag_op_e          op_i,
  input  logic             apply_i,
  input  tag_type_e        nxt_type_i,
  input  tag_act_e         tag_act_i,
  input  logic [TAG_W-1:0] new_tag_i,
  input  logic             done_d_i,
  input  logic             err_d_i,
  output tag_type_e        type_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             atomic_o,
  output logic             done_o,
  output logic             err_o
);
  tag_type_e        type_q;
  logic [TAG_W-1:0] tag_q;
  logic             atomic_q, done_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q   <= TT_EMPTY;
      tag_q    <= '0;
      atomic_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= done_d_i;
      err_q  <= err_d_i;
      if (apply_i) begin
        type_q   <= nxt_type_i;
        atomic_q <= (nxt_type_i == TT_ATOMIC);
      end
      unique case (tag_act_i)
        TA_LOAD:  tag_q <= new_tag_i;
        TA_CLEAR: tag_q <= '0;
        default:  ;
      endcase
    end
  end

  assign type_o   = type_q;
  assign tag_o    = tag_q;
  assign atomic_o = atomic_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

  AST_NN_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(type_q) == TT_EMPTY && type_q != TT_EMPTY)
      |-> ($past(op_i) == OP_GRANT || $past(op_i) == OP_NSW))
    else $error("empty type left by illegal path"); // R4

  AST_ERR_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> ($stable(type_q) && $stable(tag_q)))
    else $error("state changed on rejected request"); // R6

  AST_NO_DONE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && err_q)) else $error("done and err together"); // R6

  AST_DESCHED_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(op_i) == OP_DESCHED) |-> (type_q == TT_EMPTY && tag_q == '0))
    else $error("deschedule did not empty"); // R3
endmodule

// File: rtl/sched_tag_tracker.sv
module sched_tag_tracker
  import sched_tag_pkg::*;
#(
  parameter int unsigned TAG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             desched_i,
  input  logic             gnt_i,
  input  logic [1:0]       gnt_type_i,
  input  logic [TAG_W-1:0] gnt_tag_i,
  input  logic             nsw_i,
  input  logic             sw_i,
  input  logic [1:0]       sw_type_i,
  input  logic [TAG_W-1:0] sw_tag_i,
  output logic [1:0]       cur_type_o,
  output logic [TAG_W-1:0] cur_tag_o,
  output logic             atomic_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int unsigned W_DESC = 0;
  localparam int unsigned W_GNT  = 1;
  localparam int unsigned W_NSW  = 2;
  localparam int unsigned W_SW   = 3;

  logic [NUM_OPS-1:0] req, win;
  tag_op_e            op;
  tag_type_e          cur_type, req_type, nxt_type;
  tag_act_e           tag_act;
  logic [TAG_W-1:0]   new_tag;
  logic               apply, done_d, err_d;

  assign req[W_DESC] = desched_i;
  assign req[W_GNT]  = gnt_i;
  assign req[W_NSW]  = nsw_i;
  assign req[W_SW]   = sw_i;

  sched_tag_arb #(.N(NUM_OPS)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .win_o  (win)
  );

  always_comb begin
    op = OP_NONE;
    if      (win[W_DESC]) op = OP_DESCHED;
    else if (win[W_GNT])  op = OP_GRANT;
    else if (win[W_NSW])  op = OP_NSW;
    else if (win[W_SW])   op = OP_SWITCH;
  end

  assign req_type = win[W_GNT] ? tag_type_e'(gnt_type_i) : tag_type_e'(sw_type_i);
  assign new_tag  = win[W_GNT] ? gnt_tag_i : sw_tag_i;

  sched_tag_rules u_rules (
    .op_i       (op),
    .cur_type_i (cur_type),
    .req_type_i (req_type),
    .nxt_type_o (nxt_type),
    .tag_act_o  (tag_act),
    .apply_o    (apply),
    .done_d_o   (done_d),
    .err_d_o    (err_d)
  );

  sched_tag_state #(.TAG_W(TAG_W)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .apply_i    (apply),
    .nxt_type_i (nxt_type),
    .tag_act_i  (tag_act),
    .new_tag_i  (new_tag),
    .done_d_i   (done_d),
    .err_d_i    (err_d),
    .type_o     (cur_type),
    .tag_o      (cur_tag_o),
    .atomic_o   (atomic_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  assign cur_type_o = cur_type;

  AST_ATOMIC_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    atomic_o == (cur_type_o == 2'd1)) else $error("atomic flag mismatch"); // R8

  AST_SW_FROM_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SWITCH && cur_type == TT_EMPTY) |=> (err_o && !done_o))
    else $error("switch from empty not rejected"); // R7
endmodule

// File: tb/sched_tag_tracker_tb_top.sv
module sched_tag_tracker_tb_top;
  localparam int unsigned TW = 32;
  localparam logic [1:0] T_ORD = 2'd0, T_ATM = 2'd1, T_NUL = 2'd2, T_EMP = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          desched, gnt, nsw, sw;
  logic [1:0]    gnt_type, sw_type;
  logic [TW-1:0] gnt_tag, sw_tag;
  logic [1:0]    cur_type;
  logic [TW-1:0] cur_tag;
  logic          atomic, done, err;
  int            total = 0;
  int            bad = 0;

  always #2.5 clk = ~clk;

  sched_tag_tracker #(.TAG_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .desched_i(desched), .gnt_i(gnt), .gnt_type_i(gnt_type), .gnt_tag_i(gnt_tag),
    .nsw_i(nsw), .sw_i(sw), .sw_type_i(sw_type), .sw_tag_i(sw_tag),
    .cur_type_o(cur_type), .cur_tag_o(cur_tag), .atomic_o(atomic),
    .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    desched = 0; gnt = 0; nsw = 0; sw = 0;
    gnt_type = 0; sw_type = 0; gnt_tag = 0; sw_tag = 0;
  endtask

  // drive one cycle of requests, sample outputs after the edge that applies them
  task automatic issue(input bit d, input bit g, input logic [1:0] gt, input logic [TW-1:0] gtag,
                       input bit n, input bit s, input logic [1:0] st, input logic [TW-1:0] stag);
    @(negedge clk);
    desched = d; gnt = g; gnt_type = gt; gnt_tag = gtag;
    nsw = n; sw = s; sw_type = st; sw_tag = stag;
    @(negedge clk);
    idle();
  endtask

  task automatic expect_st(input string req, input logic [1:0] et, input logic [TW-1:0] etag,
                           input bit ed, input bit ee);
    chk(cur_type == et, req, 64'(cur_type), 64'(et));
    chk(cur_tag == etag, req, 64'(cur_tag), 64'(etag));
    chk(done == ed, req, 64'(done), 64'(ed));
    chk(err == ee, req, 64'(err), 64'(ee));
    chk(atomic == (et == T_ATM), "R8", 64'(atomic), 64'(et == T_ATM));
  endtask

  task automatic t_reset();
    expect_st("R1", T_EMP, '0, 0, 0);
  endtask

  task automatic t_empty_rules();
    issue(0, 0, 0, 0, 0, 1, T_ORD, 32'h11); expect_st("R7", T_EMP, '0, 0, 1);
    @(negedge clk); chk(err == 0, "R6", 64'(err), 0);
    issue(0, 0, 0, 0, 1, 0, 0, 0);          expect_st("R10", T_NUL, '0, 1, 0);
    issue(0, 0, 0, 0, 0, 1, T_NUL, 32'h22); expect_st("R7", T_NUL, '0, 0, 1);
    issue(0, 0, 0, 0, 1, 0, 0, 0);          expect_st("R10", T_NUL, '0, 0, 1);
  endtask

  task automatic t_switches();
    issue(0, 0, 0, 0, 0, 1, T_ORD, 32'hA0A0_0001); expect_st("R2", T_ORD, 32'hA0A0_0001, 1, 0);
    @(negedge clk); chk(done == 0, "R2", 64'(done), 0);
    issue(0, 0, 0, 0, 0, 1, T_ATM, 32'hB0B0_0002); expect_st("R2", T_ATM, 32'hB0B0_0002, 1, 0);
    issue(0, 0, 0, 0, 0, 1, T_EMP, 32'hDEAD_BEEF); expect_st("R7", T_ATM, 32'hB0B0_0002, 0, 1);
    issue(0, 0, 0, 0, 0, 1, T_NUL, 32'hC0C0_0003); expect_st("R2", T_NUL, 32'hC0C0_0003, 1, 0);
  endtask

  task automatic t_desched_grant();
    issue(1, 0, 0, 0, 0, 0, 0, 0);                 expect_st("R3", T_EMP, '0, 1, 0);
    issue(0, 1, T_EMP, 32'h55, 0, 0, 0, 0);        expect_st("R5", T_EMP, '0, 0, 1);
    issue(0, 1, T_ATM, 32'hD00D_0004, 0, 0, 0, 0); expect_st("R5", T_ATM, 32'hD00D_0004, 1, 0);
    issue(0, 0, 0, 0, 1, 0, 0, 0);                 expect_st("R10", T_NUL, 32'hD00D_0004, 1, 0);
    issue(0, 1, T_ORD, 32'h0000_0777, 0, 0, 0, 0); expect_st("R5", T_ORD, 32'h0000_0777, 1, 0);
    issue(1, 0, 0, 0, 0, 0, 0, 0);                 expect_st("R4", T_EMP, '0, 1, 0);
  endtask

  task automatic t_priority();
    issue(0, 1, T_ATM, 32'h1234, 0, 0, 0, 0);          expect_st("R9", T_ATM, 32'h1234, 1, 0);
    issue(1, 1, T_ORD, 32'h99, 1, 1, T_ORD, 32'h88);   expect_st("R9", T_EMP, '0, 1, 0);
    issue(0, 1, T_ORD, 32'hE1, 1, 1, T_ATM, 32'hE2);   expect_st("R9", T_ORD, 32'hE1, 1, 0);
    issue(0, 0, 0, 0, 1, 1, T_ATM, 32'hE3);            expect_st("R9", T_NUL, 32'hE1, 1, 0);
    // rejected winner must not let the loser through
    issue(0, 0, 0, 0, 1, 1, T_ORD, 32'hE4);            expect_st("R9", T_NUL, 32'hE1, 0, 1);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty_rules();
    t_switches();
    t_desched_grant();
    t_priority();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog act=hang exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule